// File: doc/BRIEF.md
# Fused Unofficial-Operation ALU

This unit evaluates the combined operations of an NMOS 8-bit processor that were never documented but that real programs still use. Each of these operations chains a logic or shift step into an arithmetic, load or store step, and several of them follow unusual flag rules. A sequencer supplies the operation code, the register file values (A, X, Y and the stack pointer low byte), the memory operand, the incoming flags and the high byte of the effective base address. It then pulses `issue` for one cycle.

One clock edge after the pulse, the unit shows the new A, X and SP values, the memory write data and write enable, and the updated N, V, Z and C flags. Read-modify-write operations present the rewritten memory byte and the register update together. The high-byte-masked stores AND their register source with (base high byte + 1) mod 256. Codes the unit does not implement leave every output equal to the incoming state and keep the write enable low. Fetching operands and decoding opcodes are the job of the surrounding core.

Top module: `fused_op_alu`

## Requirements
- R1: While reset is applied, and until the internal synchronized reset releases, all outputs are zero and `we` is low.
- R2: Code 0 (and-shift-right): t = A & M; A becomes t >> 1, C takes t bit 0, N is cleared, Z is set when the new A is zero, and V is unchanged.
- R3: Code 1 (and-carry): A becomes A & M, N is bit 7 of the result, Z is set when the result is zero, and C equals the new N.
- R4: Code 2 (and-rotate-right) in binary mode: r = {C, (A & M) >> 1}; A becomes r, N is r bit 7, Z is set when r is zero, C is r bit 6, and V is r bit 6 XOR r bit 5.
- R5: Code 2 in decimal mode (`dec_in` = 1 and DECIMAL_EN = 1): r as in R4. N is the old C, Z is set when r is zero, and V is bit 6 of (r XOR (A & M)). If r[3:0] + r[0] > 5, the low nibble becomes (r[3:0] + 6) mod 16. Then, if high nibble + bit 4 > 5, the high nibble gains 6 mod 16 and C is set; otherwise C is cleared.
- R6: Code 3 (and-subtract-to-X): X becomes ((A & X) - M) mod 256 with no borrow input. C is set when (A & X) >= M, N and Z follow the new X, and A is unchanged.
- R7: Codes 4, 5 and 6 drive `wdata` with (A & X), X or Y respectively, ANDed with (base_hi + 1) mod 256, and raise `we`. The flags and registers stay unchanged.
- R8: Code 7 loads SP with A & X and writes (A & X) & ((base_hi + 1) mod 256) with `we` high.
- R9: Code 8 (load-with-stack): v = M & SP is placed in A, X and SP. N and Z follow v.
- R10: Codes 9, 10 and 11 are read-modify-write operations. They write M << 1 (C = M bit 7) then OR it into A; M >> 1 (C = M bit 0) then XOR it into A; {M[6:0], C} (C = M bit 7) then AND it into A. Each raises `we` in the same cycle as the A update, and N and Z follow the new A.
- R11: Codes 12 to 15 leave A, X, SP and all flags equal to their inputs and keep `we` low.
- R12: Results appear one clock after `issue` is sampled high. In a cycle without `issue`, `we` falls and every other output holds its value.
- R13: With DECIMAL_EN = 0, `dec_in` is ignored and code 2 always follows R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Execute the presented operation this cycle |
| op | input | 4 | Operation code |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| sp_in | input | 8 | Stack pointer low byte |
| mem_in | input | 8 | Memory operand |
| base_hi | input | 8 | High byte of the base address |
| c_in | input | 1 | Carry flag in |
| n_in | input | 1 | Sign flag in |
| v_in | input | 1 | Overflow flag in |
| z_in | input | 1 | Zero flag in |
| dec_in | input | 1 | Decimal mode enable |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New X |
| sp_out | output | 8 | New stack pointer low byte |
| wdata | output | 8 | Memory write value |
| we | output | 1 | Memory write enable |
| n_out | output | 1 | Sign flag |
| v_out | output | 1 | Overflow flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag |

## Verification
The bench builds two copies of the block. The first uses the default parameters (DECIMAL_EN = 1, SYNC_STAGES = 2), which makes the nibble-correcting decimal rotate reachable together with every other code. The second sets DECIMAL_EN = 0 and receives the same decimal-mode vector, so the ignored decimal input shows up at its outputs. The directed vectors cover the zero-result cases, a base high byte of 0xFF (mask wraps to zero) and equal subtraction operands.

// File: rtl/fused_op_pkg.sv
package fused_op_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned OPW = 4;
  localparam int unsigned NIB = DW / 2;

  typedef enum logic [OPW-1:0] {
    OP_ANDSHR  = 4'd0,
    OP_ANDCRY  = 4'd1,
    OP_ANDROR  = 4'd2,
    OP_ANDSUBX = 4'd3,
    OP_STMAX   = 4'd4,
    OP_STMX    = 4'd5,
    OP_STMY    = 4'd6,
    OP_STMSP   = 4'd7,
    OP_LDSTK   = 4'd8,
    OP_SHLOR   = 4'd9,
    OP_SHREOR  = 4'd10,
    OP_ROLAND  = 4'd11
  } op_e;

  localparam logic [OPW-1:0] OP_FIRST_FREE = 4'd12;

  typedef struct packed {
    logic [DW-1:0] a;
    logic [DW-1:0] x;
    logic [DW-1:0] sp;
    logic [DW-1:0] wd;
    logic          we;
    logic          n;
    logic          v;
    logic          z;
    logic          c;
  } res_t;
endpackage

// File: rtl/fused_op_rst_sync.sv
module fused_op_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fused_op_logic.sv
module fused_op_logic
  import fused_op_pkg::*;
#(
  parameter bit DECIMAL_EN = 1'b1
) (
  input  logic [OPW-1:0] op,
  input  res_t           base,
  input  logic [DW-1:0]  mem,
  input  logic           dec,
  output res_t           res,
  output logic           hit
);
  logic          dec_act;
  logic [DW-1:0] t;
  logic [DW-1:0] rot;
  logic [DW:0]   diff;
  logic [NIB:0]  lo_sum;
  logic [NIB:0]  hi_sum;
  logic [DW-1:0] mid;
  logic [DW-1:0] dfix;
  logic          dcarry;

  generate
    if (DECIMAL_EN) begin : g_dec
      assign dec_act = dec;
    end else begin : g_bin
      assign dec_act = 1'b0;
    end
  endgenerate

  assign t    = base.a & mem;
  assign rot  = {base.c, t[DW-1:1]};
  assign diff = {1'b0, base.a & base.x} - {1'b0, mem};

  // nibble correction for the decimal rotate
  always_comb begin
    lo_sum = {1'b0, rot[NIB-1:0]} + {{NIB{1'b0}}, rot[0]};
    mid    = rot;
    if (lo_sum > 5) mid[NIB-1:0] = rot[NIB-1:0] + 4'd6;
    hi_sum = {1'b0, mid[DW-1:NIB]} + {{NIB{1'b0}}, mid[NIB]};
    dfix   = mid;
    dcarry = 1'b0;
    if (hi_sum > 5) begin
      dfix[DW-1:NIB] = mid[DW-1:NIB] + 4'd6;
      dcarry         = 1'b1;
    end
  end

  always_comb begin
    res = base;
    hit = 1'b1;
    case (op)
      OP_ANDSHR: begin
        res.a = {1'b0, t[DW-1:1]};
        res.c = t[0];
        res.n = 1'b0;
        res.z = (t[DW-1:1] == '0);
      end
      OP_ANDCRY: begin
        res.a = t;
        res.n = t[DW-1];
        res.c = t[DW-1];
        res.z = (t == '0);
      end
      OP_ANDROR: begin
        res.z = (rot == '0);
        if (dec_act) begin
          res.a = dfix;
          res.n = base.c;
          res.v = rot[6] ^ t[6];
          res.c = dcarry;
        end else begin
          res.a = rot;
          res.n = rot[DW-1];
          res.v = rot[6] ^ rot[5];
          res.c = rot[6];
        end
      end
      OP_ANDSUBX: begin
        res.x = diff[DW-1:0];
        res.c = ~diff[DW];
        res.n = diff[DW-1];
        res.z = (diff[DW-1:0] == '0);
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fused_op_store.sv
module fused_op_store
  import fused_op_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  res_t           base,
  input  logic [DW-1:0]  y,
  input  logic [DW-1:0]  mem,
  input  logic [DW-1:0]  base_hi,
  output res_t           res,
  output logic           hit
);
  logic [DW-1:0] mask;
  logic [DW-1:0] ax;
  logic [DW-1:0] stk;

  assign mask = base_hi + 1'b1;
  assign ax   = base.a & base.x;
  assign stk  = mem & base.sp;

  always_comb begin
    res = base;
    hit = 1'b1;
    case (op)
      OP_STMAX: begin
        res.wd = ax & mask;
        res.we = 1'b1;
      end
      OP_STMX: begin
        res.wd = base.x & mask;
        res.we = 1'b1;
      end
      OP_STMY: begin
        res.wd = y & mask;
        res.we = 1'b1;
      end
      OP_STMSP: begin
        res.sp = ax;
        res.wd = ax & mask;
        res.we = 1'b1;
      end
      OP_LDSTK: begin
        res.a  = stk;
        res.x  = stk;
        res.sp = stk;
        res.n  = stk[DW-1];
        res.z  = (stk == '0);
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fused_op_rmw.sv
module fused_op_rmw
  import fused_op_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  res_t           base,
  input  logic [DW-1:0]  mem,
  output res_t           res,
  output logic           hit
);
  logic [DW-1:0] mod;
  logic [DW-1:0] acc;
  logic          cout;

  always_comb begin
    hit  = 1'b1;
    mod  = mem;
    acc  = base.a;
    cout = base.c;
    case (op)
      OP_SHLOR: begin
        mod  = {mem[DW-2:0], 1'b0};
        cout = mem[DW-1];
        acc  = base.a | mod;
      end
      OP_SHREOR: begin
        mod  = {1'b0, mem[DW-1:1]};
        cout = mem[0];
        acc  = base.a ^ mod;
      end
      OP_ROLAND: begin
        mod  = {mem[DW-2:0], base.c};
        cout = mem[DW-1];
        acc  = base.a & mod;
      end
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    res = base;
    if (hit) begin
      res.wd = mod;
      res.we = 1'b1;
      res.a  = acc;
      res.c  = cout;
      res.n  = acc[DW-1];
      res.z  = (acc == '0);
    end
  end
endmodule

// File: rtl/fused_op_alu.sv
module fused_op_alu
  import fused_op_pkg::*;
#(
  parameter bit          DECIMAL_EN  = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a_in,
  input  logic [DW-1:0]  x_in,
  input  logic [DW-1:0]  y_in,
  input  logic [DW-1:0]  sp_in,
  input  logic [DW-1:0]  mem_in,
  input  logic [DW-1:0]  base_hi,
  input  logic           c_in,
  input  logic           n_in,
  input  logic           v_in,
  input  logic           z_in,
  input  logic           dec_in,
  output logic [DW-1:0]  a_out,
  output logic [DW-1:0]  x_out,
  output logic [DW-1:0]  sp_out,
  output logic [DW-1:0]  wdata,
  output logic           we,
  output logic           n_out,
  output logic           v_out,
  output logic           z_out,
  output logic           c_out
);
  logic rst_n_s;
  res_t base, r_log, r_st, r_rmw, nxt, state_q;
  logic hit_log, hit_st, hit_rmw;

  fused_op_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    base    = '0;
    base.a  = a_in;
    base.x  = x_in;
    base.sp = sp_in;
    base.n  = n_in;
    base.v  = v_in;
    base.z  = z_in;
    base.c  = c_in;
  end

  fused_op_logic #(.DECIMAL_EN(DECIMAL_EN)) u_log (
    .op(op), .base(base), .mem(mem_in), .dec(dec_in), .res(r_log), .hit(hit_log)
  );

  fused_op_store u_st (
    .op(op), .base(base), .y(y_in), .mem(mem_in), .base_hi(base_hi),
    .res(r_st), .hit(hit_st)
  );

  fused_op_rmw u_rmw (
    .op(op), .base(base), .mem(mem_in), .res(r_rmw), .hit(hit_rmw)
  );

  always_comb begin
    if (hit_log)      nxt = r_log;
    else if (hit_st)  nxt = r_st;
    else if (hit_rmw) nxt = r_rmw;
    else              nxt = base;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= '0;
    end else if (issue) begin
      state_q <= nxt;
    end else begin
      state_q.we <= 1'b0;
    end
  end

  assign a_out  = state_q.a;
  assign x_out  = state_q.x;
  assign sp_out = state_q.sp;
  assign wdata  = state_q.wd;
  assign we     = state_q.we;
  assign n_out  = state_q.n;
  assign v_out  = state_q.v;
  assign z_out  = state_q.z;
  assign c_out  = state_q.c;
endmodule

// File: rtl/fused_op_alu_chk.sv
module fused_op_alu_chk
  import fused_op_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           issue,
  input logic [OPW-1:0] op,
  input logic [DW-1:0]  a_in,
  input logic [DW-1:0]  x_in,
  input logic [DW-1:0]  sp_in,
  input logic           c_in,
  input logic           n_in,
  input logic           v_in,
  input logic           z_in,
  input logic [DW-1:0]  a_out,
  input logic [DW-1:0]  x_out,
  input logic [DW-1:0]  sp_out,
  input logic [DW-1:0]  wdata,
  input logic           we,
  input logic           n_out,
  input logic           v_out,
  input logic           z_out,
  input logic           c_out
);
  AST_WE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !we); // R12
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(a_out) && $stable(x_out) && $stable(sp_out) && $stable(wdata)
               && $stable(n_out) && $stable(v_out) && $stable(z_out) && $stable(c_out))); // R12
  AST_FREE_CODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op >= OP_FIRST_FREE) |=> (!we && a_out == $past(a_in) && x_out == $past(x_in)
      && sp_out == $past(sp_in) && c_out == $past(c_in) && n_out == $past(n_in)
      && v_out == $past(v_in) && z_out == $past(z_in))); // R11
  AST_SHR_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_ANDSHR) |=> !n_out); // R2
  AST_CARRY_IS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_ANDCRY) |=> (c_out == n_out)); // R3
  AST_STACK_LOAD_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_LDSTK) |=> (a_out == x_out && x_out == sp_out && !we)); // R9
  AST_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op >= OP_STMAX && op <= OP_STMSP) |=> (we && c_out == $past(c_in))); // R7
  AST_RMW_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op >= OP_SHLOR && op <= OP_ROLAND) |=> we); // R10
endmodule

bind fused_op_alu fused_op_alu_chk u_chk (.*);

// File: tb/fused_op_alu_test.sv
`timescale 1ns/1ps
module fused_op_alu_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       issue;
  logic [3:0] op;
  logic [7:0] a_in, x_in, y_in, sp_in, mem_in, base_hi;
  logic       c_in, n_in, v_in, z_in, dec_in;
  logic [7:0] a_out, x_out, sp_out, wdata;
  logic       we, n_out, v_out, z_out, c_out;
  logic [7:0] a2, x2, sp2, wd2;
  logic       we2, n2, v2, z2, c2;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  fused_op_alu uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .a_in(a_in), .x_in(x_in),
    .y_in(y_in), .sp_in(sp_in), .mem_in(mem_in), .base_hi(base_hi), .c_in(c_in),
    .n_in(n_in), .v_in(v_in), .z_in(z_in), .dec_in(dec_in), .a_out(a_out),
    .x_out(x_out), .sp_out(sp_out), .wdata(wdata), .we(we), .n_out(n_out),
    .v_out(v_out), .z_out(z_out), .c_out(c_out)
  );

  fused_op_alu #(.DECIMAL_EN(1'b0)) uut_bin (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .a_in(a_in), .x_in(x_in),
    .y_in(y_in), .sp_in(sp_in), .mem_in(mem_in), .base_hi(base_hi), .c_in(c_in),
    .n_in(n_in), .v_in(v_in), .z_in(z_in), .dec_in(dec_in), .a_out(a2),
    .x_out(x2), .sp_out(sp2), .wdata(wd2), .we(we2), .n_out(n2),
    .v_out(v2), .z_out(z2), .c_out(c2)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got,
                     input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [3:0] exp_nvzc);
    chk(req, "NVZC", {4'b0, n_out, v_out, z_out, c_out}, {4'b0, exp_nvzc});
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] a, input logic [7:0] x,
                     input logic [7:0] y, input logic [7:0] sp, input logic [7:0] m,
                     input logic [7:0] bh, input logic [3:0] nvzc, input logic d);
    @(negedge clk);
    op = o; a_in = a; x_in = x; y_in = y; sp_in = sp; mem_in = m; base_hi = bh;
    {n_in, v_in, z_in, c_in} = nvzc; dec_in = d; issue = 1'b1;
    @(posedge clk);
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "a_out", a_out, 8'h00);
    chk("R1", "sp_out", sp_out, 8'h00);
    chk("R1", "we", {7'b0, we}, 8'h00);
    chk_flags("R1", 4'b0000);
  endtask

  task automatic t_andshr;
    run(4'd0, 8'hF3, 8'h00, 8'h00, 8'h00, 8'h5F, 8'h00, 4'b1100, 1'b0);
    chk("R2", "A", a_out, 8'h29); chk_flags("R2", 4'b0101);
    run(4'd0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 4'b0000, 1'b0);
    chk("R2", "A zero", a_out, 8'h00); chk_flags("R2", 4'b0011);
  endtask

  task automatic t_andcry;
    run(4'd1, 8'hC0, 8'h00, 8'h00, 8'h00, 8'h81, 8'h00, 4'b0010, 1'b0);
    chk("R3", "A", a_out, 8'h80); chk_flags("R3", 4'b1001);
    run(4'd1, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h70, 8'h00, 4'b1001, 1'b0);
    chk("R3", "A zero", a_out, 8'h00); chk_flags("R3", 4'b0010);
  endtask

  task automatic t_andror_bin;
    run(4'd2, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hC5, 8'h00, 4'b0001, 1'b0);
    chk("R4", "A", a_out, 8'hE2); chk_flags("R4", 4'b1001);
    run(4'd2, 8'h40, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 4'b0000, 1'b0);
    chk("R4", "A", a_out, 8'h20); chk_flags("R4", 4'b0100);
  endtask

  task automatic t_andror_dec;
    run(4'd2, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h9B, 8'h00, 4'b0000, 1'b1);
    chk("R5", "A low fix", a_out, 8'h43); chk_flags("R5", 4'b0100);
    run(4'd2, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hB5, 8'h00, 4'b0001, 1'b1);
    chk("R5", "A both fix", a_out, 8'h30); chk_flags("R5", 4'b1101);
    chk("R13", "A binary copy", a2, 8'hDA);
    chk("R13", "NVZC binary copy", {4'b0, n2, v2, z2, c2}, 8'h0D);
  endtask

  task automatic t_subx;
    run(4'd3, 8'hF0, 8'h3C, 8'h00, 8'h00, 8'h10, 8'h00, 4'b0000, 1'b0);
    chk("R6", "X", x_out, 8'h20); chk("R6", "A kept", a_out, 8'hF0);
    chk_flags("R6", 4'b0001);
    run(4'd3, 8'hFF, 8'h05, 8'h00, 8'h00, 8'h06, 8'h00, 4'b0101, 1'b0);
    chk("R6", "X wrap", x_out, 8'hFF); chk_flags("R6", 4'b1100);
    run(4'd3, 8'h0F, 8'hF7, 8'h00, 8'h00, 8'h07, 8'h00, 4'b0000, 1'b0);
    chk("R6", "X equal", x_out, 8'h00); chk_flags("R6", 4'b0011);
  endtask

  task automatic t_stores;
    run(4'd4, 8'hFF, 8'h7E, 8'h00, 8'h00, 8'h00, 8'h12, 4'b1011, 1'b0);
    chk("R7", "wdata A&X", wdata, 8'h12); chk("R7", "we", {7'b0, we}, 8'h01);
    chk_flags("R7", 4'b1011);
    run(4'd5, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h3F, 4'b0000, 1'b0);
    chk("R7", "wdata X", wdata, 8'h40);
    run(4'd6, 8'h00, 8'h00, 8'hAA, 8'h00, 8'h00, 8'hFF, 4'b0000, 1'b0);
    chk("R7", "wdata Y wrap mask", wdata, 8'h00); chk("R7", "we", {7'b0, we}, 8'h01);
    run(4'd7, 8'hF7, 8'h3F, 8'h00, 8'h55, 8'h00, 8'h04, 4'b0000, 1'b0);
    chk("R8", "SP", sp_out, 8'h37); chk("R8", "wdata", wdata, 8'h05);
    chk("R8", "we", {7'b0, we}, 8'h01);
  endtask

  task automatic t_ldstk;
    run(4'd8, 8'h00, 8'h00, 8'h00, 8'h9C, 8'hF0, 8'h00, 4'b0010, 1'b0);
    chk("R9", "A", a_out, 8'h90); chk("R9", "X", x_out, 8'h90);
    chk("R9", "SP", sp_out, 8'h90); chk_flags("R9", 4'b1000);
    run(4'd8, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h0F, 8'h00, 4'b1000, 1'b0);
    chk("R9", "SP zero", sp_out, 8'h00); chk_flags("R9", 4'b0010);
  endtask

  task automatic t_rmw;
    run(4'd9, 8'h01, 8'h00, 8'h00, 8'h00, 8'h81, 8'h00, 4'b0000, 1'b0);
    chk("R10", "shl wdata", wdata, 8'h02); chk("R10", "shl A", a_out, 8'h03);
    chk("R10", "we", {7'b0, we}, 8'h01); chk_flags("R10", 4'b0001);
    run(4'd10, 8'h80, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 4'b0000, 1'b0);
    chk("R10", "shr wdata", wdata, 8'h01); chk("R10", "shr A", a_out, 8'h81);
    chk_flags("R10", 4'b1001);
    run(4'd11, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 4'b0001, 1'b0);
    chk("R10", "rol wdata", wdata, 8'h81); chk("R10", "rol A", a_out, 8'h81);
    chk_flags("R10", 4'b1000);
  endtask

  task automatic t_free_codes;
    run(4'd14, 8'h11, 8'h22, 8'h44, 8'h33, 8'hFF, 8'h00, 4'b1010, 1'b1);
    chk("R11", "A", a_out, 8'h11); chk("R11", "X", x_out, 8'h22);
    chk("R11", "SP", sp_out, 8'h33); chk("R11", "we", {7'b0, we}, 8'h00);
    chk_flags("R11", 4'b1010);
    run(4'd12, 8'h5A, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 4'b0101, 1'b0);
    chk("R11", "A code 12", a_out, 8'h5A); chk_flags("R11", 4'b0101);
  endtask

  task automatic t_idle;
    run(4'd9, 8'h01, 8'h00, 8'h00, 8'h00, 8'h81, 8'h00, 4'b0000, 1'b0);
    mem_in = 8'h00; a_in = 8'hEE;
    @(posedge clk); @(negedge clk);
    chk("R12", "we falls", {7'b0, we}, 8'h00);
    chk("R12", "A holds", a_out, 8'h03);
    chk("R12", "wdata holds", wdata, 8'h02);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue = 1'b0; op = '0; a_in = '0; x_in = '0; y_in = '0;
    sp_in = '0; mem_in = '0; base_hi = '0; c_in = 0; n_in = 0; v_in = 0; z_in = 0;
    dec_in = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_andshr;
    t_andcry;
    t_andror_bin;
    t_andror_dec;
    t_subx;
    t_stores;
    t_ldstk;
    t_rmw;
    t_free_codes;
    t_idle;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule